// File: doc/BRIEF.md
# Byte-Aligned Instruction Length Decoder

This block sits behind an instruction byte fetch path and splits a big-endian stream of bytes into instructions. Because an instruction may begin at any byte address, the block tracks boundaries one byte at a time. It classifies each instruction from a variable-length prefix held in the most significant bits of its first two bytes. That prefix yields a length of 2 to 20 bytes and a 4-bit format class. A small counter then skips the remaining bytes of the instruction, so that the byte right after the last one is taken as the next instruction's first byte.

Bytes enter through a valid/ready handshake. Each byte leaves the block once, in order, together with its byte address. The first byte of an instruction carries a start flag, the instruction length and the format class. A prefix decision can need up to ten bits, so the first byte of an instruction is held until the second byte has been accepted. A flush input discards any byte the block is holding, clears the boundary counter and loads a new byte address. The next byte accepted is then the start of an instruction.

Top module: `ilen_decoder`

## Requirements
- R1: The byte that follows the last byte of an instruction is always reported as the start of the next instruction, whatever its value. Bytes inside an instruction are never decoded as prefixes, and output addresses advance by one per byte.
- R2: A first byte whose top bit is 0 gives length 4 and class 0, unless R3 applies.
- R3: These prefixes are checked before R2. Top ten bits 0111110110 give length 12, class 9. Top ten bits 0111110111 give length 20, class 10. Top seven bits 0111111 give length 18, class 11. Any other prefix that starts 0111110 falls back to R2.
- R4: Prefix 10 gives length 4, class 1. Prefix 110000 gives length 4, class 2, the halfword-immediate format. Prefix 110001 gives length 3, class 3.
- R5: Prefix 11001 gives length 8, class 4. Prefix 1101 gives length 6, class 5. Prefix 11111 gives length 10, class 8.
- R6: Prefix 1110 gives length 2, class 6. Prefix 11110 gives length 2, class 7.
- R7: out_start is 1 only on the first byte of an instruction, and out_len and out_class are valid with that byte. On every other byte, out_len and out_class are 0.
- R8: The first byte of an instruction appears on the output in the cycle after the second byte is accepted, and not before. Any other byte appears no later than the cycle after it is accepted. Every accepted byte appears exactly once, in order.
- R9: While flush is high, in_ready is low and nothing is emitted in the following cycle. A held byte is dropped, the boundary count is cleared, and the next accepted byte is a start at flush_addr. Addresses wrap modulo 2^AW.
- R10: After reset, out_valid is 0, in_ready is 1, and the first accepted byte is a start at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restart boundary tracking |
| flush_addr | input | AW | Byte address of the next accepted byte after a flush |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Byte passed through |
| out_start | output | 1 | Byte is the first of an instruction |
| out_len | output | 5 | Instruction length in bytes, on start bytes |
| out_class | output | 4 | Format class, on start bytes |
| out_addr | output | AW | Byte address of out_byte |

## Verification
The bench builds the decoder with AW set to 12 rather than the default 16. This lets a flush load an address two bytes below the top of the space, so that a single four-byte instruction wraps its addresses through zero. Every prefix row is sent once with back-to-back bytes and once with idle cycles between bytes. The rows include the 0111110 patterns that sit on either side of the long-format carve-outs. Bytes inside instructions are filled with values that look like short prefixes, so the bench would see a skip count that is off by even one byte.

// File: rtl/ilen_decoder.sv
module ilen_decoder #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_byte,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic          out_start,
  output logic [4:0]    out_len,
  output logic [3:0]    out_class,
  output logic [AW-1:0] out_addr
);

  logic          pend_v, pend_start;
  logic [7:0]    pend_byte;
  logic [AW-1:0] pend_addr, next_addr;
  logic [4:0]    cnt;
  logic [4:0]    cls_len;
  logic [3:0]    cls_code;
  logic          acc, emit, in_is_start;
  logic [9:0]    pfx;

  assign in_ready    = ~flush;
  assign acc         = in_valid & in_ready;
  assign emit        = ~flush & pend_v & (~pend_start | acc);
  assign in_is_start = (cnt == 5'd0) & ~(pend_v & pend_start);
  assign pfx         = {pend_byte, in_byte[7:6]};

  always_comb begin
    casez (pfx)
      10'b0111110110: begin cls_len = 5'd12; cls_code = 4'd9;  end
      10'b0111110111: begin cls_len = 5'd20; cls_code = 4'd10; end
      10'b0111111???: begin cls_len = 5'd18; cls_code = 4'd11; end
      10'b0?????????: begin cls_len = 5'd4;  cls_code = 4'd0;  end
      10'b10????????: begin cls_len = 5'd4;  cls_code = 4'd1;  end
      10'b110000????: begin cls_len = 5'd4;  cls_code = 4'd2;  end
      10'b110001????: begin cls_len = 5'd3;  cls_code = 4'd3;  end
      10'b11001?????: begin cls_len = 5'd8;  cls_code = 4'd4;  end
      10'b1101??????: begin cls_len = 5'd6;  cls_code = 4'd5;  end
      10'b1110??????: begin cls_len = 5'd2;  cls_code = 4'd6;  end
      10'b11110?????: begin cls_len = 5'd2;  cls_code = 4'd7;  end
      default:        begin cls_len = 5'd10; cls_code = 4'd8;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_start <= 1'b0;
      pend_byte  <= '0;
      pend_addr  <= '0;
      next_addr  <= '0;
      cnt        <= '0;
      out_valid  <= 1'b0;
      out_byte   <= '0;
      out_start  <= 1'b0;
      out_len    <= '0;
      out_class  <= '0;
      out_addr   <= '0;
    end else if (flush) begin
      pend_v     <= 1'b0;
      pend_start <= 1'b0;
      cnt        <= '0;
      next_addr  <= flush_addr;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_byte  <= pend_byte;
        out_addr  <= pend_addr;
        out_start <= pend_start;
        out_len   <= pend_start ? cls_len : 5'd0;
        out_class <= pend_start ? cls_code : 4'd0;
      end
      if (acc) begin
        pend_v     <= 1'b1;
        pend_byte  <= in_byte;
        pend_addr  <= next_addr;
        next_addr  <= next_addr + 1'b1;
        pend_start <= in_is_start;
        if (pend_v && pend_start)
          cnt <= cls_len - 5'd2;
        else if (cnt != 5'd0)
          cnt <= cnt - 5'd1;
      end else if (emit) begin
        pend_v <= 1'b0;
      end
    end
  end

  AST_CONT_UNTAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_start |-> out_len == 5'd0 && out_class == 4'd0); // R7

  AST_START_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_start |-> out_len inside {5'd2, 5'd3, 5'd4, 5'd6, 5'd8,
                                                5'd10, 5'd12, 5'd18, 5'd20}); // R7

  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> out_addr == $past(out_addr) + 1'b1); // R1

  AST_START_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_start |-> $past(in_valid && in_ready)); // R8

endmodule

// File: tb/sim_ilen_decoder.sv
`timescale 1ns/1ps
module sim_ilen_decoder;
  localparam int AW = 12;
  localparam int NV = 17;
  localparam logic [24:0] VEC [NV] = '{
    {8'h00, 8'h00, 5'd4,  4'd0},
    {8'h7C, 8'h00, 5'd4,  4'd0},
    {8'h7D, 8'h40, 5'd4,  4'd0},
    {8'h7D, 8'h80, 5'd12, 4'd9},
    {8'h7D, 8'hC0, 5'd20, 4'd10},
    {8'h7E, 8'h00, 5'd18, 4'd11},
    {8'h7F, 8'hFF, 5'd18, 4'd11},
    {8'h80, 8'h12, 5'd4,  4'd1},
    {8'hBF, 8'hFF, 5'd4,  4'd1},
    {8'hC0, 8'h34, 5'd4,  4'd2},
    {8'hC4, 8'h56, 5'd3,  4'd3},
    {8'hC8, 8'h78, 5'd8,  4'd4},
    {8'hD0, 8'h9A, 5'd6,  4'd5},
    {8'hE0, 8'hBC, 5'd2,  4'd6},
    {8'hF0, 8'hDE, 5'd2,  4'd7},
    {8'hF8, 8'hF0, 5'd10, 4'd8},
    {8'hEF, 8'h01, 5'd2,  4'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 1'b0, in_valid = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic [7:0] in_byte = '0;
  logic in_ready, out_valid, out_start;
  logic [7:0] out_byte;
  logic [4:0] out_len;
  logic [3:0] out_class;
  logic [AW-1:0] out_addr;

  always #2.5 clk = ~clk;

  ilen_decoder #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_start(out_start),
    .out_len(out_len), .out_class(out_class), .out_addr(out_addr));

  int checks = 0, errors = 0, wr = 0, rd = 0;
  logic [7:0]    e_byte [1024];
  logic          e_start[1024];
  logic [4:0]    e_len  [1024];
  logic [3:0]    e_cls  [1024];
  logic [AW-1:0] e_addr [1024];
  logic [AW-1:0] baddr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd0: return "R2";
      4'd9, 4'd10, 4'd11: return "R3";
      4'd1, 4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd8: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic expect_byte(input logic [7:0] b, input logic st,
                             input logic [4:0] l, input logic [3:0] c);
    e_byte[wr] = b; e_start[wr] = st; e_len[wr] = l; e_cls[wr] = c;
    e_addr[wr] = baddr;
    wr++;
    baddr = baddr + 1'b1;
  endtask

  task automatic send(input logic [7:0] b);
    in_byte = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_instr(input logic [7:0] f, input logic [7:0] s,
                            input logic [4:0] l, input logic [3:0] c, input bit gap);
    for (int k = 0; k < int'(l); k++) begin
      logic [7:0] b;
      b = (k == 0) ? f : (k == 1) ? s : (8'hE0 ^ 8'(k));
      expect_byte(b, k == 0, k == 0 ? l : 5'd0, k == 0 ? c : 4'd0);
      send(b);
      if (gap) @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) begin
        check(1'b0, "R8", "unexpected output byte", out_byte, 0);
      end else begin
        check(out_byte == e_byte[rd], "R1", "byte", out_byte, e_byte[rd]);
        check(out_addr == e_addr[rd], "R1", "address", out_addr, e_addr[rd]);
        check(out_start == e_start[rd], "R7", "start flag", out_start, e_start[rd]);
        if (e_start[rd]) begin
          check(out_len == e_len[rd], req_of(e_cls[rd]), "length", out_len, e_len[rd]);
          check(out_class == e_cls[rd], req_of(e_cls[rd]), "class", out_class, e_cls[rd]);
        end else begin
          check(out_len == 0 && out_class == 0, "R7", "continuation tag",
                {out_len, out_class}, 0);
        end
        rd++;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "state after reset",
          {out_valid, in_ready}, 1);

    for (int p = 0; p < 2; p++)
      for (int i = 0; i < NV; i++)
        send_instr(VEC[i][24:17], VEC[i][16:9], VEC[i][8:4], VEC[i][3:0], p == 1);
    repeat (4) @(negedge clk);

    // R8: a start byte is held until its second byte arrives
    expect_byte(8'hC4, 1'b1, 5'd3, 4'd3);
    send(8'hC4);
    for (int k = 0; k < 3; k++) begin
      check(out_valid == 1'b0, "R8", "start byte released early", out_valid, 0);
      @(negedge clk);
    end
    expect_byte(8'h11, 1'b0, 5'd0, 4'd0);
    send(8'h11);
    check(out_valid && out_start, "R8", "start after second byte",
          {out_valid, out_start}, 3);
    expect_byte(8'hE0, 1'b0, 5'd0, 4'd0);
    send(8'hE0);
    check(out_valid && !out_start, "R8", "continuation next cycle",
          {out_valid, out_start}, 2);
    @(negedge clk);
    check(out_valid && !out_start && out_byte == 8'hE0, "R1",
          "last byte not a start", {out_valid, out_start, out_byte}, 10'h2E0);
    repeat (3) @(negedge clk);

    // R9: flush drops a held start byte and wraps the address
    send(8'hC8);
    flush = 1'b1; flush_addr = 12'hFFE;
    #1 check(in_ready == 1'b0, "R9", "in_ready during flush", in_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    check(out_valid == 1'b0, "R9", "output after flush", out_valid, 0);
    baddr = 12'hFFE;
    send_instr(8'h00, 8'h5A, 5'd4, 4'd0, 1'b0);
    repeat (3) @(negedge clk);

    // R9: flush in the middle of an instruction clears the skip count
    expect_byte(8'hC8, 1'b1, 5'd8, 4'd4);
    expect_byte(8'h22, 1'b0, 5'd0, 4'd0);
    send(8'hC8); send(8'h22); send(8'h33);
    flush = 1'b1; flush_addr = 12'h020;
    @(negedge clk);
    flush = 1'b0;
    check(out_valid == 1'b0, "R9", "held byte dropped", out_valid, 0);
    baddr = 12'h020;
    send_instr(8'hF0, 8'hC8, 5'd2, 4'd7, 1'b0);
    send_instr(8'hD0, 8'h00, 5'd6, 4'd5, 1'b1);
    repeat (5) @(negedge clk);
    check(rd == wr, "R8", "all bytes emitted", rd, wr);
    finish_run();
  end
endmodule